// File: doc/BRIEF.md
# Global Control and Notification Register Bank

This block holds the device-wide control and status state of a streaming audio endpoint, addressed in 32-bit quadlets over a simple request/response register bus. The bus offers quadlet reads, quadlet writes and a 64-bit compare-swap. The bank stores the 64-bit address of the controller that owns the device. It also keeps the last notification event word, a clock-select field, a stream-enable flag, a clock status word, and an extended status word. That word shows the live lock state and sticky slip flags of eleven clock sources.

Events come from several places: configuration-change pulses from the stream sections, changes in the lock of the current source, any change in the per-source lock vector, and a completed clock-select write. Whenever one or more of these occur in a cycle, that set of bits replaces the stored notification word. If the device has an owner, the block raises a send request that carries the word and the owner address. The request stays up until a send acknowledge arrives. A bus-reset input drops ownership and stops streaming.

Quadlet map (word addresses): 0 owner bits 63:32, 1 owner bits 31:0, 2 notification, 3 clock select, 4 stream enable, 5 clock status, 6 extended status. Operation codes on `req_op`: 0 read, 1 write, 2 compare-swap, 3 reserved.

Top module: `gctl_regbank`

## Requirements
- R1: After reset, the owner holds 0xFFFF000000000000 (no owner), clock select reads 0x020C (internal source code 12, rate code 2), stream enable is 0, the notification word is 0 and no send request is raised.
- R2: The owner changes only through a compare-swap at address 0. The owner takes `req_wdata` only when its value equals `req_cmp`, and the response data is the owner value from before the operation. A quadlet write to address 0 or 1 leaves the owner unchanged.
- R3: A bus-reset cycle returns the owner to the no-owner value and clears stream enable, and it takes priority over a compare-swap or enable write in the same cycle.
- R4: In any cycle with at least one event, the notification word becomes exactly that cycle's event set, and earlier bits are dropped. Bit 0 means receive configuration changed, bit 1 transmit configuration changed, bit 4 current-source lock changed, bit 5 clock-select write accepted, and bit 6 some source's lock changed.
- R5: A write to address 3 stores `req_wdata[15:0]` (source code in bits 7:0, rate code in bits 15:8), ignores the upper bits, drives `clk_select`, and raises event bit 5.
- R6: Extended status bits 10:0 show the registered source lock vector, and any change of `src_lock` raises event bit 6. Clock status bit 0 shows the registered current lock, bits 15:8 show `cur_rate`, and a change of `cur_lock` raises event bit 4.
- R7: A pulse on `src_slip[i]` sets extended status bit 16+i until a quadlet read of address 6 returns it and clears it. Slips raise no event.
- R8: A slip pulse in the same cycle as a clearing read of address 6 leaves its flag set, and the flag is absent from that read's data.
- R9: A send request is raised only when the owner is not the no-owner value. It carries the event word and the owner address, and it stays raised until `ntf_ack` is seen. A new event while the request is pending replaces the word.
- R10: Writes to addresses 0, 1, 2, 5 and 6, any access above address 6, a compare-swap at any address other than 0, and operation code 3 are all ignored and answered with `rsp_err` set.
- R11: A write to address 4 sets stream enable to 1 when `req_wdata[31:0]` is non-zero and to 0 otherwise. Every request is answered one cycle later on `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Serial-bus reset indication, one cycle |
| req_valid | input | 1 | Register request strobe |
| req_op | input | 2 | 0 read, 1 write, 2 compare-swap |
| req_addr | input | AW | Quadlet address |
| req_wdata | input | 64 | Write data (low 32 bits for writes), swap value for compare-swap |
| req_cmp | input | 64 | Compare value for compare-swap |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Request was refused |
| rsp_rdata | output | 64 | Read data or old owner value |
| src_lock | input | NSRC | Live lock state per clock source |
| src_slip | input | NSRC | Slip pulse per clock source |
| cur_lock | input | 1 | Lock state of the selected source |
| cur_rate | input | 8 | Nominal rate code of the selected source |
| cfg_rx_chg | input | 1 | Receive configuration change pulse |
| cfg_tx_chg | input | 1 | Transmit configuration change pulse |
| clk_select | output | 16 | Stored clock select value |
| stream_en | output | 1 | Stream enable flag |
| ntf_req | output | 1 | Notification send request |
| ntf_ack | input | 1 | Send acknowledge |
| ntf_addr | output | 64 | Destination (owner) address |
| ntf_word | output | 32 | Notification word to send |

## Verification
Two functions can land on the same clock edge. The first is the clearing read of the extended status word together with a fresh slip pulse. The bench issues the read of address 6 in the same cycle as a slip on one source, expects that read to lack the new flag, and expects the next read to show it. The second is a bus reset together with a compare-swap that would otherwise match. It is judged by reading the owner back as the no-owner value. A behavioural reference model in the bench is compared with the response, notification and control outputs on every clock.

// File: rtl/gctl_pkg.sv
package gctl_pkg;

  typedef enum logic [1:0] {
    OP_RD    = 2'd0,
    OP_WR    = 2'd1,
    OP_CSWAP = 2'd2,
    OP_RSVD  = 2'd3
  } bus_op_e;

  localparam logic [63:0] OWNER_NONE = 64'hFFFF_0000_0000_0000;
  localparam logic [15:0] CSEL_RESET = 16'h020C;

  // quadlet addresses
  localparam int QA_OWN_HI = 0;
  localparam int QA_OWN_LO = 1;
  localparam int QA_NOTE   = 2;
  localparam int QA_CSEL   = 3;
  localparam int QA_EN     = 4;
  localparam int QA_STAT   = 5;
  localparam int QA_XSTAT  = 6;

  // notification bit positions
  localparam int NB_RX      = 0;
  localparam int NB_TX      = 1;
  localparam int NB_CURLOCK = 4;
  localparam int NB_CSEL    = 5;
  localparam int NB_XSTAT   = 6;

  localparam int SLIP_LSB = 16;

endpackage

// File: rtl/gctl_owner.sv
module gctl_owner
  import gctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_reset,
  input  logic        swap_en,
  input  logic [63:0] cmp_val,
  input  logic [63:0] new_val,
  output logic [63:0] owner_q
);
  always_ff @(posedge clk) begin
    if (rst || bus_reset) begin
      owner_q <= OWNER_NONE;
    end else if (swap_en && (owner_q == cmp_val)) begin
      owner_q <= new_val;
    end
  end
endmodule

// File: rtl/gctl_xstat.sv
module gctl_xstat #(
  parameter int NSRC = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] lock_in,
  input  logic [NSRC-1:0] slip_in,
  input  logic            rd_clr,
  output logic [NSRC-1:0] lock_q,
  output logic [NSRC-1:0] slip_q,
  output logic            lock_chg
);
  assign lock_chg = (lock_in != lock_q);

  always_ff @(posedge clk) begin
    if (rst) lock_q <= '0;
    else     lock_q <= lock_in;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_slip
    always_ff @(posedge clk) begin
      if (rst) slip_q[i] <= 1'b0;
      else     slip_q[i] <= (slip_q[i] & ~rd_clr) | slip_in[i];
    end
  end
endmodule

// File: rtl/gctl_notify.sv
module gctl_notify
  import gctl_pkg::*;
#(
  parameter int EW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_reset,
  input  logic [EW-1:0] events,
  input  logic [63:0]   owner,
  input  logic          ack,
  output logic [EW-1:0] notif_q,
  output logic          req_q,
  output logic [EW-1:0] word_q,
  output logic [63:0]   addr_q
);
  logic any_ev;
  logic owned;

  assign any_ev = |events;
  assign owned  = (owner != OWNER_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      notif_q <= '0;
      req_q   <= 1'b0;
      word_q  <= '0;
      addr_q  <= '0;
    end else begin
      if (any_ev) notif_q <= events;
      if (bus_reset) begin
        req_q <= 1'b0;
      end else if (any_ev && owned) begin
        req_q  <= 1'b1;
        word_q <= events;
        addr_q <= owner;
      end else if (req_q && ack) begin
        req_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gctl_regbank.sv
module gctl_regbank
  import gctl_pkg::*;
#(
  parameter int AW   = 4,
  parameter int NSRC = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_reset,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [63:0]     req_wdata,
  input  logic [63:0]     req_cmp,
  output logic            rsp_valid,
  output logic            rsp_err,
  output logic [63:0]     rsp_rdata,
  input  logic [NSRC-1:0] src_lock,
  input  logic [NSRC-1:0] src_slip,
  input  logic            cur_lock,
  input  logic [7:0]      cur_rate,
  input  logic            cfg_rx_chg,
  input  logic            cfg_tx_chg,
  output logic [15:0]     clk_select,
  output logic            stream_en,
  output logic            ntf_req,
  input  logic            ntf_ack,
  output logic [63:0]     ntf_addr,
  output logic [31:0]     ntf_word
);
  localparam int EW = 32;
  localparam logic [AW-1:0] A_OWN_HI = AW'(QA_OWN_HI);
  localparam logic [AW-1:0] A_OWN_LO = AW'(QA_OWN_LO);
  localparam logic [AW-1:0] A_NOTE   = AW'(QA_NOTE);
  localparam logic [AW-1:0] A_CSEL   = AW'(QA_CSEL);
  localparam logic [AW-1:0] A_EN     = AW'(QA_EN);
  localparam logic [AW-1:0] A_STAT   = AW'(QA_STAT);
  localparam logic [AW-1:0] A_XSTAT  = AW'(QA_XSTAT);

  logic            is_rd, is_wr, is_cs;
  logic            rd_ok, wr_csel, wr_en, cs_ok, bad;
  logic [63:0]     owner_q;
  logic [NSRC-1:0] lock_q, slip_q;
  logic            lock_chg;
  logic            cur_q, cur_chg;
  logic [EW-1:0]   events;
  logic [EW-1:0]   notif_q;
  logic [31:0]     xstat_w, stat_w;
  logic [63:0]     rd_word;

  // request decode
  assign is_rd   = req_valid && (req_op == OP_RD);
  assign is_wr   = req_valid && (req_op == OP_WR);
  assign is_cs   = req_valid && (req_op == OP_CSWAP);
  assign rd_ok   = is_rd && (req_addr <= A_XSTAT);
  assign wr_csel = is_wr && (req_addr == A_CSEL);
  assign wr_en   = is_wr && (req_addr == A_EN);
  assign cs_ok   = is_cs && (req_addr == A_OWN_HI);
  assign bad     = req_valid && !(rd_ok || wr_csel || wr_en || cs_ok);

  gctl_owner u_owner (
    .clk       (clk),
    .rst       (rst),
    .bus_reset (bus_reset),
    .swap_en   (cs_ok),
    .cmp_val   (req_cmp),
    .new_val   (req_wdata),
    .owner_q   (owner_q)
  );

  gctl_xstat #(.NSRC(NSRC)) u_xstat (
    .clk      (clk),
    .rst      (rst),
    .lock_in  (src_lock),
    .slip_in  (src_slip),
    .rd_clr   (is_rd && (req_addr == A_XSTAT)),
    .lock_q   (lock_q),
    .slip_q   (slip_q),
    .lock_chg (lock_chg)
  );

  // current-source lock tracking
  assign cur_chg = (cur_lock != cur_q);
  always_ff @(posedge clk) begin
    if (rst) cur_q <= 1'b0;
    else     cur_q <= cur_lock;
  end

  // event collection
  always_comb begin
    events             = '0;
    events[NB_RX]      = cfg_rx_chg;
    events[NB_TX]      = cfg_tx_chg;
    events[NB_CURLOCK] = cur_chg;
    events[NB_CSEL]    = wr_csel;
    events[NB_XSTAT]   = lock_chg;
  end

  gctl_notify #(.EW(EW)) u_notify (
    .clk       (clk),
    .rst       (rst),
    .bus_reset (bus_reset),
    .events    (events),
    .owner     (owner_q),
    .ack       (ntf_ack),
    .notif_q   (notif_q),
    .req_q     (ntf_req),
    .word_q    (ntf_word),
    .addr_q    (ntf_addr)
  );

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_select <= CSEL_RESET;
    end else if (wr_csel) begin
      clk_select <= req_wdata[15:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || bus_reset) begin
      stream_en <= 1'b0;
    end else if (wr_en) begin
      stream_en <= |req_wdata[31:0];
    end
  end

  // status words
  always_comb begin
    stat_w        = '0;
    stat_w[0]     = cur_q;
    stat_w[15:8]  = cur_rate;
    xstat_w                    = '0;
    xstat_w[NSRC-1:0]          = lock_q;
    xstat_w[SLIP_LSB +: NSRC]  = slip_q;
  end

  // read mux
  always_comb begin
    rd_word = '0;
    if (is_cs) begin
      rd_word = owner_q;
    end else if (rd_ok) begin
      unique case (req_addr)
        A_OWN_HI: rd_word[31:0] = owner_q[63:32];
        A_OWN_LO: rd_word[31:0] = owner_q[31:0];
        A_NOTE:   rd_word[31:0] = notif_q;
        A_CSEL:   rd_word[31:0] = {16'h0, clk_select};
        A_EN:     rd_word[31:0] = {31'h0, stream_en};
        A_STAT:   rd_word[31:0] = stat_w;
        A_XSTAT:  rd_word[31:0] = xstat_w;
        default:  rd_word       = '0;
      endcase
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= bad;
      rsp_rdata <= bad ? 64'h0 : rd_word;
    end
  end

endmodule

// File: rtl/gctl_regbank_chk.sv
module gctl_regbank_chk
  import gctl_pkg::*;
#(
  parameter int NSRC = 11
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_reset,
  input logic            req_valid,
  input logic [1:0]      req_op,
  input logic            rsp_valid,
  input logic            stream_en,
  input logic            ntf_req,
  input logic            ntf_ack,
  input logic [63:0]     ntf_addr,
  input logic [31:0]     ntf_word,
  input logic [63:0]     owner_q,
  input logic [NSRC-1:0] src_slip,
  input logic [NSRC-1:0] slip_q
);
  AST_BUSRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> (owner_q == OWNER_NONE) && !stream_en); // R3

  AST_OWNER_VIA_SWAP: assert property (@(posedge clk) disable iff (rst)
    !$stable(owner_q) |-> $past(bus_reset || (req_valid && (req_op == OP_CSWAP)))); // R2

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (ntf_req && !ntf_ack && !bus_reset) |=> ntf_req); // R9

  AST_REQ_HAS_OWNER: assert property (@(posedge clk) disable iff (rst)
    $rose(ntf_req) |-> (ntf_addr != OWNER_NONE)); // R9

  AST_WORD_NONZERO: assert property (@(posedge clk) disable iff (rst)
    ntf_req |-> (ntf_word != 32'h0)); // R4

  AST_SLIP_STICKS: assert property (@(posedge clk) disable iff (rst)
    (|src_slip) |=> ((slip_q & $past(src_slip)) == $past(src_slip))); // R8

  AST_RSP_ONE_LATER: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R11
endmodule

bind gctl_regbank gctl_regbank_chk #(.NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_reset (bus_reset),
  .req_valid (req_valid),
  .req_op    (req_op),
  .rsp_valid (rsp_valid),
  .stream_en (stream_en),
  .ntf_req   (ntf_req),
  .ntf_ack   (ntf_ack),
  .ntf_addr  (ntf_addr),
  .ntf_word  (ntf_word),
  .owner_q   (owner_q),
  .src_slip  (src_slip),
  .slip_q    (slip_q)
);

// File: tb/test_gctl_regbank.sv
module test_gctl_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int NSRC = 11;
  localparam logic [63:0] NONE = 64'hFFFF_0000_0000_0000;
  localparam logic [63:0] OWNA = 64'h0001_0000_0000_1000;
  localparam logic [63:0] OWNB = 64'h0002_0000_0000_2000;

  logic clk = 0, rst = 1, bus_reset = 0;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0;
  logic [63:0] req_wdata = 0, req_cmp = 0;
  logic rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic [NSRC-1:0] src_lock = 0, src_slip = 0;
  logic cur_lock = 0;
  logic [7:0] cur_rate = 8'h02;
  logic cfg_rx_chg = 0, cfg_tx_chg = 0;
  logic [15:0] clk_select;
  logic stream_en, ntf_req, ntf_ack = 1;
  logic [63:0] ntf_addr;
  logic [31:0] ntf_word;

  int checks = 0, failures = 0;
  string cur_tag = "R1";
  logic [63:0] last_data;
  logic last_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  gctl_regbank #(.AW(AW), .NSRC(NSRC)) i_gctl_regbank (
    .clk(clk), .rst(rst), .bus_reset(bus_reset),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_cmp(req_cmp),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .src_lock(src_lock), .src_slip(src_slip), .cur_lock(cur_lock),
    .cur_rate(cur_rate), .cfg_rx_chg(cfg_rx_chg), .cfg_tx_chg(cfg_tx_chg),
    .clk_select(clk_select), .stream_en(stream_en),
    .ntf_req(ntf_req), .ntf_ack(ntf_ack), .ntf_addr(ntf_addr), .ntf_word(ntf_word)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_owner;
  logic        m_en, m_cur, m_req, m_rv, m_rerr;
  logic [15:0] m_csel;
  logic [31:0] m_notif, m_word;
  logic [63:0] m_addr, m_rdata;
  logic [NSRC-1:0] m_lock, m_slip;

  always @(posedge clk) begin : model
    logic [31:0] ev;
    logic [63:0] n_owner;
    logic [NSRC-1:0] n_slip;
    logic n_en;
    if (rst) begin
      m_owner = NONE; m_en = 0; m_cur = 0; m_req = 0; m_rv = 0; m_rerr = 0;
      m_csel = 16'h020C; m_notif = 0; m_word = 0; m_addr = 0; m_rdata = 0;
      m_lock = 0; m_slip = 0;
    end else begin
      ev = 0;
      if (cfg_rx_chg) ev = ev | 32'h01;
      if (cfg_tx_chg) ev = ev | 32'h02;
      if (cur_lock != m_cur) ev = ev | 32'h10;
      if (src_lock != m_lock) ev = ev | 32'h40;
      n_owner = m_owner; n_slip = m_slip; n_en = m_en;
      m_rv = req_valid; m_rerr = 0; m_rdata = 0;
      if (req_valid) begin
        if (req_op == 2'd0 && int'(req_addr) <= 6) begin
          case (int'(req_addr))
            0: m_rdata = {32'h0, m_owner[63:32]};
            1: m_rdata = {32'h0, m_owner[31:0]};
            2: m_rdata = {32'h0, m_notif};
            3: m_rdata = {48'h0, m_csel};
            4: m_rdata = {63'h0, m_en};
            5: m_rdata = {48'h0, cur_rate, 7'h0, m_cur};
            default: begin
              m_rdata = {32'h0, 5'h0, m_slip, 5'h0, m_lock};
              n_slip = 0;
            end
          endcase
        end else if (req_op == 2'd1 && req_addr == 3) begin
          m_csel = req_wdata[15:0]; ev = ev | 32'h20;
        end else if (req_op == 2'd1 && req_addr == 4) begin
          n_en = (req_wdata[31:0] != 0);
        end else if (req_op == 2'd2 && req_addr == 0) begin
          m_rdata = m_owner;
          if (m_owner == req_cmp) n_owner = req_wdata;
        end else begin
          m_rerr = 1;
        end
      end
      n_slip = n_slip | src_slip;
      if (ev != 0) m_notif = ev;
      if (bus_reset) m_req = 0;
      else if (ev != 0 && m_owner != NONE) begin
        m_req = 1; m_word = ev; m_addr = m_owner;
      end else if (m_req && ntf_ack) m_req = 0;
      if (bus_reset) begin n_owner = NONE; n_en = 0; end
      m_owner = n_owner; m_en = n_en; m_slip = n_slip;
      m_cur = cur_lock; m_lock = src_lock;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk({cur_tag, " rsp_valid"}, {63'h0, rsp_valid}, {63'h0, m_rv});
      if (m_rv) begin
        chk({cur_tag, " rsp_err"}, {63'h0, rsp_err}, {63'h0, m_rerr});
        chk({cur_tag, " rsp_rdata"}, rsp_rdata, m_rdata);
      end
      chk({cur_tag, " ntf_req"}, {63'h0, ntf_req}, {63'h0, m_req});
      if (m_req) begin
        chk({cur_tag, " ntf_word"}, {32'h0, ntf_word}, {32'h0, m_word});
        chk({cur_tag, " ntf_addr"}, ntf_addr, m_addr);
      end
      chk({cur_tag, " clk_select"}, {48'h0, clk_select}, {48'h0, m_csel});
      chk({cur_tag, " stream_en"}, {63'h0, stream_en}, {63'h0, m_en});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic bus_op(input logic [1:0] op, input int addr,
                        input logic [63:0] wd, input logic [63:0] cm);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = AW'(addr); req_wdata = wd; req_cmp = cm;
    @(negedge clk);
    req_valid = 0;
    last_data = rsp_rdata; last_err = rsp_err;
  endtask

  task automatic rd(input int addr);
    bus_op(2'd0, addr, 64'h0, 64'h0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    cur_tag = "R1";
    rd(0); chk("R1 owner hi", last_data, 64'h0000_0000_FFFF_0000);
    rd(1); chk("R1 owner lo", last_data, 64'h0);
    rd(2); chk("R1 notif", last_data, 64'h0);
    chk("R1 clk_select", {48'h0, clk_select}, 64'h020C);
    chk("R1 stream_en", {63'h0, stream_en}, 64'h0);
    chk("R1 ntf_req", {63'h0, ntf_req}, 64'h0);

    // R9 no owner: event recorded but no request
    cur_tag = "R9";
    @(negedge clk); cfg_rx_chg = 1; @(negedge clk); cfg_rx_chg = 0;
    chk("R9 no request without owner", {63'h0, ntf_req}, 64'h0);
    rd(2); chk("R4 notif rx bit", last_data, 64'h1);

    // R2 compare-swap
    cur_tag = "R2";
    bus_op(2'd2, 0, OWNA, 64'h0);
    chk("R2 mismatch returns old", last_data, NONE);
    rd(0); chk("R2 mismatch keeps owner", last_data, 64'hFFFF_0000);
    bus_op(2'd2, 0, OWNA, NONE);
    chk("R2 match returns old", last_data, NONE);
    rd(0); chk("R2 owner hi", last_data, 64'h0001_0000);
    rd(1); chk("R2 owner lo", last_data, 64'h1000);
    bus_op(2'd1, 1, 64'h0, 64'h0);
    chk("R2 quadlet write to owner refused", {63'h0, last_err}, 64'h1);
    rd(1); chk("R2 owner lo unchanged", last_data, 64'h1000);

    // R9 hold until ack, R4 replacement
    cur_tag = "R9";
    ntf_ack = 0;
    @(negedge clk); cfg_tx_chg = 1; @(negedge clk); cfg_tx_chg = 0;
    chk("R9 request raised", {63'h0, ntf_req}, 64'h1);
    chk("R9 word", {32'h0, ntf_word}, 64'h2);
    chk("R9 addr", ntf_addr, OWNA);
    idle(3);
    chk("R9 held without ack", {63'h0, ntf_req}, 64'h1);
    cur_tag = "R4";
    @(negedge clk); cfg_rx_chg = 1; @(negedge clk); cfg_rx_chg = 0;
    chk("R4 word replaced", {32'h0, ntf_word}, 64'h1);
    rd(2); chk("R4 notif replaced", last_data, 64'h1);
    ntf_ack = 1;
    @(negedge clk);
    chk("R9 dropped after ack", {63'h0, ntf_req}, 64'h0);

    // R5 clock select
    cur_tag = "R5";
    bus_op(2'd1, 3, 64'h0000_0000_1234_0605, 64'h0);
    chk("R5 clk_select", {48'h0, clk_select}, 64'h0605);
    rd(2); chk("R5 accepted event", last_data, 64'h20);
    rd(3); chk("R5 readback", last_data, 64'h0605);

    // R6 lock changes
    cur_tag = "R6";
    @(negedge clk); src_lock = 11'h005;
    @(negedge clk);
    rd(2); chk("R6 source lock event", last_data, 64'h40);
    rd(6); chk("R6 lock bits", last_data, 64'h5);
    @(negedge clk); src_lock = 11'h007; cur_lock = 1;
    @(negedge clk);
    rd(2); chk("R6 combined events", last_data, 64'h50);
    rd(5); chk("R6 status word", last_data, 64'h201);

    // R7 slip flags
    cur_tag = "R7";
    @(negedge clk); src_slip = 11'h011; @(negedge clk); src_slip = 0;
    chk("R7 no request from slip", {63'h0, ntf_req}, 64'h0);
    rd(2); chk("R7 notif untouched", last_data, 64'h50);
    rd(6); chk("R7 slip visible", last_data, 64'h0011_0007);
    rd(6); chk("R7 cleared by read", last_data, 64'h7);

    // R8 slip in the same cycle as the clearing read
    cur_tag = "R8";
    @(negedge clk);
    req_valid = 1; req_op = 2'd0; req_addr = AW'(6); src_slip = 11'h008;
    @(negedge clk);
    req_valid = 0; src_slip = 0;
    chk("R8 read lacks new slip", rsp_rdata, 64'h7);
    rd(6); chk("R8 slip kept", last_data, 64'h0008_0007);

    // R11 enable
    cur_tag = "R11";
    bus_op(2'd1, 4, 64'h5, 64'h0);
    chk("R11 enable set", {63'h0, stream_en}, 64'h1);
    rd(4); chk("R11 enable read", last_data, 64'h1);

    // R10 refused requests
    cur_tag = "R10";
    bus_op(2'd1, 2, 64'hFF, 64'h0); chk("R10 write notif", {63'h0, last_err}, 64'h1);
    bus_op(2'd1, 6, 64'hFF, 64'h0); chk("R10 write xstat", {63'h0, last_err}, 64'h1);
    bus_op(2'd0, 9, 64'h0, 64'h0);  chk("R10 read unmapped", {63'h0, last_err}, 64'h1);
    bus_op(2'd3, 3, 64'h0, 64'h0);  chk("R10 reserved op", {63'h0, last_err}, 64'h1);
    bus_op(2'd2, 3, 64'h0, 64'h020C); chk("R10 swap wrong addr", {63'h0, last_err}, 64'h1);
    rd(3); chk("R10 clk_select kept", last_data, 64'h0605);

    // R3 bus reset
    cur_tag = "R3";
    @(negedge clk); bus_reset = 1; @(negedge clk); bus_reset = 0;
    chk("R3 enable cleared", {63'h0, stream_en}, 64'h0);
    rd(0); chk("R3 owner cleared", last_data, 64'hFFFF_0000);
    bus_op(2'd2, 0, OWNA, NONE);
    @(negedge clk);
    req_valid = 1; req_op = 2'd2; req_addr = 0; req_wdata = OWNB; req_cmp = OWNA;
    bus_reset = 1;
    @(negedge clk);
    req_valid = 0; bus_reset = 0;
    rd(0); chk("R3 reset beats swap", last_data, 64'hFFFF_0000);
    rd(1); chk("R3 owner lo", last_data, 64'h0);

    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule